// File: doc/BRIEF.md
# Audio Sample Clock Generator with Glitch-Free Ratio Control

This block turns a fast system clock into the master sample clock of an audio codec. A host programs one 8-bit control register through a single write port, and can read it back on a separate read port. The register can stop the sample clock, select one of four divide ratios, and choose between the undivided base-rate clock and the divided clock. The base rate is a square wave whose half period is `BASE_HALF` fast cycles. It stands for the highest sampling rate, nominally 48 kHz. The divided clock runs at that rate over 2, 4, 6 or 8, which gives nominal 24, 12, 8 and 6 kHz sampling.

A glitch-free ratio change comes from the host following four steps. First it sets the stop bit. Then it writes the new ratio code with stop still set, clears stop, and finally sets the select bit. While the clock is stopped the output is low and every counter is held at zero, so a restart always begins from a known phase. A ratio code written while the clock runs is stored but not used until the next stop.

Top module: `sclk_gen`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and the output runs undivided, with a period of 2*BASE_HALF fast cycles.
- R2: Readback bits 7..4 are always zero. Bits 3..0 read back as last written, with bit 3 = select, bit 2 = stop and bits 1..0 = ratio code.
- R3: When bit 3 is clear and the clock runs, the output has a period of 2*BASE_HALF cycles and is high for BASE_HALF of them.
- R4: When bit 3 is set and the clock runs, the output has a period of 2*BASE_HALF*N cycles with a 50% duty cycle. N is 2, 4, 6 or 8 for codes 00, 01, 10 and 11 in bits 1..0.
- R5: Setting bit 2 drives the output low from the first cycle after the write, and it stays low while the bit stays set.
- R6: After a write that clears bit 2, the first rising edge of the output comes exactly BASE_HALF*M fast cycles after that write's clock edge. M is N when bit 3 is set and 1 when it is clear.
- R7: A ratio code written while the clock runs is stored and read back at once, but the output period keeps the old ratio until the clock has been stopped.
- R8: Writing 0x00 leaves the clock running undivided at the base rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| smp_clk | output | 1 | Generated codec sample clock |

## Verification
The main function is tried with the undivided setting and with all four ratio codes, each reached through the full four-step sequence. Measuring both the period and the high time separates a wrong ratio from a wrong duty cycle or toggle spacing. Restart latency is measured from the clearing write, once undivided and once divided, which shows whether the counters really restart from zero. A ratio change while running, followed by a stop and restart, shows whether a new code reaches the counter early or only when the clock is stopped.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int RATIO_MAX = 8;
    localparam int DCW       = $clog2(RATIO_MAX);

    // Field layout of the control register low nibble
    typedef struct packed {
        logic       sel;   // bit 3: divided path
        logic       stop;  // bit 2: halt clock
        logic [1:0] code;  // bits 1..0: ratio code
    } cfg_t;

    // Last count value of the divider: ratio - 1 = 2*code + 1
    function automatic logic [DCW-1:0] ratio_last(input logic [1:0] code);
        return {code, 1'b1};
    endfunction

endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
    import sclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output cfg_t       cfg,
    output logic [7:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr_en)
            cfg <= cfg_t'(wr_data[3:0]);
    end

    assign rd_data = {4'b0000, cfg};

    // R2: readback follows the last write on the next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[3:0] == $past(wr_data[3:0])));

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclk_pkg::*;
#(
    parameter int BASE_HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    input  logic [1:0] code,
    output logic       base_sq,
    output logic       div_sq
);

    localparam int PW = (BASE_HALF > 1) ? $clog2(BASE_HALF) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(BASE_HALF - 1);

    logic [PW-1:0]  pre_cnt;
    logic [DCW-1:0] div_cnt;
    logic [1:0]     act_code;
    logic           base_edge;

    assign base_edge = (pre_cnt == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            pre_cnt  <= '0;
            div_cnt  <= '0;
            base_sq  <= 1'b0;
            div_sq   <= 1'b0;
            act_code <= rst ? 2'b00 : code;
        end else if (base_edge) begin
            pre_cnt <= '0;
            base_sq <= ~base_sq;
            if (div_cnt == ratio_last(act_code)) begin
                div_cnt <= '0;
                div_sq  <= ~div_sq;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R5: a stopped clock parks the counters at zero
    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (rst)
        stop |=> (pre_cnt == '0 && div_cnt == '0 && !base_sq && !div_sq));

    // R7: the applied ratio code never moves while the clock runs
    assert_code_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !stop |=> $stable(act_code));

    // R4: divider count stays inside the selected ratio
    assert_divcnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        !stop |-> (div_cnt <= ratio_last(act_code)));

    // R3: base square wave toggles only at the prescaler wrap
    assert_base_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (!stop && !base_edge) |=> $stable(base_sq));

endmodule

// File: rtl/sclk_out_sel.sv
module sclk_out_sel (
    input  logic stop,
    input  logic sel,
    input  logic base_sq,
    input  logic div_sq,
    output logic clk_out
);

    always_comb begin
        if (stop)
            clk_out = 1'b0;
        else if (sel)
            clk_out = div_sq;
        else
            clk_out = base_sq;
    end

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_pkg::*;
#(
    parameter int BASE_HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       smp_clk
);

    cfg_t cfg;
    logic base_sq;
    logic div_sq;

    sclk_cfg_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    sclk_divider #(.BASE_HALF(BASE_HALF)) u_div (
        .clk     (clk),
        .rst     (rst),
        .stop    (cfg.stop),
        .code    (cfg.code),
        .base_sq (base_sq),
        .div_sq  (div_sq)
    );

    sclk_out_sel u_sel (
        .stop    (cfg.stop),
        .sel     (cfg.sel),
        .base_sq (base_sq),
        .div_sq  (div_sq),
        .clk_out (smp_clk)
    );

    // R5: output is low in the cycle after a stop write
    assert_stop_low_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[2]) |=> !smp_clk);

    // R1: reset clears the register
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00));

endmodule

// File: tb/sclk_gen_bench.sv
module sclk_gen_bench;

    localparam int H     = 4;
    localparam int VEC_N = 5;
    // table: {sel, stop, code} targets walked by the loop
    localparam logic [3:0] V_CFG [VEC_N] = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       smp_clk;

    int n_run  = 0;
    int n_fail = 0;
    logic [3:0] cur = 4'h0;

    always #5 clk = ~clk;

    sclk_gen #(.BASE_HALF(H)) u_sclk_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .smp_clk (smp_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        cur     = v[3:0];
    endtask

    // measure high time and period from one rising edge to the next
    task automatic measure(output int hi, output int per);
        int t;
        hi = -1; per = -1;
        t = 0;
        @(negedge clk);
        while (smp_clk && t < 2000) begin @(negedge clk); t++; end
        while (!smp_clk && t < 2000) begin @(negedge clk); t++; end
        if (t >= 2000) return;
        hi = 0; per = 0;
        while (smp_clk && per < 2000) begin @(negedge clk); hi++; per++; end
        while (!smp_clk && per < 2000) begin @(negedge clk); per++; end
    endtask

    task automatic latency(output int c);
        c = 0;
        while (!smp_clk && c < 2000) begin @(negedge clk); c++; end
    endtask

    task automatic program_seq(input logic [3:0] tgt);
        wr({4'h0, cur[3], 1'b1, cur[1:0]});
        wr({6'h01, tgt[1:0]});
        wr({6'h00, tgt[1:0]});
        if (tgt[3]) wr({6'h02, tgt[1:0]});
    endtask

    function automatic int exp_period(input logic [3:0] c);
        int n;
        n = c[3] ? 2 * (int'(c[1:0]) + 1) : 1;
        return 2 * H * n;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before all requirement checks ended");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int hi, per, lat, lows;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 readback after reset", int'(rd_data), 0);
        measure(hi, per);
        chk("R1 period after reset", per, 2 * H);

        // table walk: R3 undivided, R4 divided codes
        for (int i = 0; i < VEC_N; i++) begin
            program_seq(V_CFG[i]);
            chk(V_CFG[i][3] ? "R4 readback" : "R3 readback", int'(rd_data), int'(V_CFG[i]));
            measure(hi, per);
            chk(V_CFG[i][3] ? "R4 period" : "R3 period", per, exp_period(V_CFG[i]));
            chk(V_CFG[i][3] ? "R4 high time" : "R3 high time", hi, exp_period(V_CFG[i]) / 2);
        end

        // R7: code change while running (now sel=1 code 3)
        wr(8'h09);
        chk("R7 stored code readback", int'(rd_data), 9);
        measure(hi, per);
        chk("R7 old ratio kept while running", per, 2 * H * 8);
        wr(8'h0D);
        wr(8'h09);
        measure(hi, per);
        chk("R7 new ratio after stop", per, 2 * H * 4);

        // R5: stop holds output low
        wr(8'h0F);
        lows = 0;
        for (int k = 0; k < 200; k++) begin
            if (!smp_clk) lows++;
            @(negedge clk);
        end
        chk("R5 output low while stopped", lows, 200);
        chk("R5 readback while stopped", int'(rd_data), 15);

        // R6: restart latency, divided code 01
        wr(8'h0D);
        wr(8'h09);
        latency(lat);
        chk("R6 divided restart latency", lat, H * 4);

        // R6 and R8: stop, then write all zeros
        wr(8'h0C);
        wr(8'h00);
        latency(lat);
        chk("R6 undivided restart latency", lat, H);
        measure(hi, per);
        chk("R8 zero write period", per, 2 * H);
        chk("R8 zero write high time", hi, H);

        // R2: reserved bits read as zero
        wr(8'hF6);
        chk("R2 reserved bits masked", int'(rd_data), 6);
        wr(8'hA0);
        chk("R2 upper nibble only", int'(rd_data), 0);

        // R1: reset during a divided run
        wr(8'h0B);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 readback after mid-run reset", int'(rd_data), 0);
        latency(lat);
        chk("R1 first rise after reset", lat, H);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule